// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

This block takes the raw bit pattern of a binary floating-point operand and turns it into a signed integer. The operand is either single precision (32 bits) or double precision (64 bits), and the target is either a 32-bit or a 64-bit two's-complement word. The rounding rule comes from a 2-bit mode field, which would normally be wired from the floating-point control/status register.

The operand is accepted with a valid strobe and the result is registered one clock later. Any NaN, infinity or out-of-range value is replaced by a fixed invalid pattern. The block also keeps a set of sticky exception bits (invalid, overflow, inexact). Each operation ORs its new flags into those bits, and a clear strobe, which stands for a software write to the status register, empties them.

Top module: `fp2i_conv`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid`, `res_int`, `res_invalid` and `res_flags` are all zero.
- R2: An operation presented with `op_valid` high at a rising edge produces its result in the cycle after that edge, with `res_valid` high. In cycles with no operation, `res_valid` is low and `res_int` and `res_invalid` keep their last values.
- R3: The `rnd_mode` field is coded as follows: 0 rounds to nearest, 1 rounds toward zero, 2 rounds toward plus infinity, 3 rounds toward minus infinity. In mode 0 a value exactly halfway between two integers goes to the even one (2.5 gives 2, 3.5 gives 4, -2.5 gives -2).
- R4: Mode 1 truncates, mode 2 takes the ceiling and mode 3 takes the floor (1.25 gives 1/2/1 and -1.75 gives -1/-1/-2 in modes 1/2/3).
- R5: With `op_dbl`=1 the operand is all 64 bits of `op_bits` in double format. With `op_dbl`=0 it is `op_bits[31:0]` in single format, and `op_bits[63:32]` has no effect on any output.
- R6: With `dst_long`=1 the target is 64 bits wide. With `dst_long`=0 it is 32 bits wide, and `res_int` carries that 32-bit result sign-extended to 64 bits.
- R7: A NaN or infinity operand gives `res_invalid`=1 and sets the invalid flag `res_flags[2]`, but not the overflow flag. The result is the largest positive value of the target width: 0x7FFFFFFF, or 0x7FFFFFFFFFFFFFFF for the 64-bit target.
- R8: A finite operand whose rounded value falls outside the signed range of the target sets both the overflow flag `res_flags[1]` and the invalid flag. It also gives `res_invalid`=1 and the same largest-positive result. A value of exactly -2^(N-1) is still in range.
- R9: The inexact flag `res_flags[0]` is set when a valid conversion changes the value. It is never set by an operation that was invalid.
- R10: The flags are sticky. Each operation ORs its flags into them, and only `flag_clr` clears them. When `flag_clr` and an operation fall in the same cycle, only that operation's flags remain.
- R11: Subnormal operands are converted exactly: the smallest positive subnormal gives 0 in modes 0, 1 and 3 and 1 in mode 2, and its negative gives -1 in mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_bits | input | 64 | Raw floating-point operand bits |
| op_dbl | input | 1 | 1: double-precision operand, 0: single in bits 31:0 |
| dst_long | input | 1 | 1: 64-bit integer target, 0: 32-bit target |
| rnd_mode | input | 2 | Rounding mode field (0 nearest-even, 1 zero, 2 plus inf, 3 minus inf) |
| flag_clr | input | 1 | Clears the sticky flags |
| res_valid | output | 1 | Result of the previous cycle's operation is present |
| res_int | output | 64 | Integer result (32-bit results sign-extended) |
| res_invalid | output | 1 | The last operation was invalid |
| res_flags | output | 3 | Sticky flags: [2] invalid, [1] overflow, [0] inexact |

## Verification
The result of an operation accepted at a rising edge is due exactly one edge later, and the sticky flags reflect it at that same point. The bench's reference model therefore updates its expectation at the same rising edge that registers the design. All outputs are compared at the falling edge that follows, when inputs and outputs are both settled. The model computes each expected integer with real arithmetic and explicit floor and ceiling, working from the operand bits alone. Idle cycles are compared as well, so the hold behaviour and the sticky flags are checked on every clock.

// File: rtl/fp2i_pkg.sv
package fp2i_pkg;

    localparam int FRAC_D   = 52;
    localparam int EXP_D    = 11;
    localparam int BIAS_D   = 1023;
    localparam int FRAC_S   = 23;
    localparam int EXP_S    = 8;
    localparam int BIAS_S   = 127;
    localparam int SIG_W    = FRAC_D + 1;
    localparam int EXP_IW   = EXP_D + 2;
    localparam int INT_W    = 64;
    localparam int NARROW_W = 32;
    localparam int N_DST    = 2;
    localparam int FLAG_W   = 3;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;

    typedef struct packed {
        logic                     sign;
        logic                     special;
        logic signed [EXP_IW-1:0] exp;
        logic [SIG_W-1:0]         sig;
    } unpacked_t;

    typedef struct packed {
        logic inv;
        logic ovf;
        logic inx;
    } flags_t;

    typedef struct packed {
        logic             valid;
        logic [INT_W-1:0] result;
        logic             inv;
        flags_t           flags;
    } state_t;

    function automatic int dst_width(input int idx);
        return (idx == 0) ? NARROW_W : INT_W;
    endfunction

endpackage

// File: rtl/fp2i_unpack.sv
module fp2i_unpack
    import fp2i_pkg::*;
(
    input  logic [INT_W-1:0] raw,
    input  logic             is_dbl,
    output unpacked_t        up
);

    localparam int PAD_W = FRAC_D - FRAC_S;

    logic [EXP_S-1:0]  exp_s;
    logic [FRAC_S-1:0] frac_s;
    logic [EXP_D-1:0]  exp_d;
    logic [FRAC_D-1:0] frac_d;

    always_comb begin
        exp_s  = raw[FRAC_S +: EXP_S];
        frac_s = raw[FRAC_S-1:0];
        exp_d  = raw[FRAC_D +: EXP_D];
        frac_d = raw[FRAC_D-1:0];
        if (is_dbl) begin
            up.sign    = raw[INT_W-1];
            up.special = &exp_d;
            up.sig     = {|exp_d, frac_d};
            up.exp     = (exp_d == '0) ? EXP_IW'(1 - BIAS_D)
                                       : EXP_IW'(int'(exp_d) - BIAS_D);
        end else begin
            up.sign    = raw[FRAC_S + EXP_S];
            up.special = &exp_s;
            up.sig     = {|exp_s, frac_s, {PAD_W{1'b0}}};
            up.exp     = (exp_s == '0) ? EXP_IW'(1 - BIAS_S)
                                       : EXP_IW'(int'(exp_s) - BIAS_S);
        end
    end

endmodule

// File: rtl/fp2i_round.sv
module fp2i_round
    import fp2i_pkg::*;
(
    input  logic                     sign,
    input  logic signed [EXP_IW-1:0] exp,
    input  logic [SIG_W-1:0]         sig,
    input  rmode_e                   mode,
    output logic [INT_W:0]           rmag,
    output logic                     inexact,
    output logic                     huge
);

    localparam int LSH_W = $clog2(INT_W);

    logic signed [EXP_IW:0] rsh;
    logic [LSH_W-1:0]       lsh;
    logic [LSH_W-1:0]       rs;
    logic [LSH_W-1:0]       rs_m1;
    logic [INT_W-1:0]       mag;
    logic                   guard;
    logic                   sticky;
    logic                   inc;

    always_comb begin
        mag    = '0;
        guard  = 1'b0;
        sticky = 1'b0;
        lsh    = '0;
        rs     = '0;
        rs_m1  = '0;
        rsh    = (EXP_IW+1)'(FRAC_D) - (EXP_IW+1)'(exp);
        huge   = (exp > EXP_IW'(INT_W - 1));
        if (exp >= EXP_IW'(FRAC_D)) begin
            if (!huge) begin
                lsh = LSH_W'(exp - EXP_IW'(FRAC_D));
                mag = INT_W'(sig) << lsh;
            end
        end else if (rsh > (EXP_IW+1)'(SIG_W)) begin
            sticky = |sig;
        end else begin
            rs     = LSH_W'(rsh);
            rs_m1  = rs - LSH_W'(1);
            mag    = INT_W'(sig >> rs);
            guard  = sig[rs_m1];
            sticky = |(sig & ((SIG_W'(1) << rs_m1) - SIG_W'(1)));
        end

        case (mode)
            RM_NEAR: inc = guard & (sticky | mag[0]);
            RM_ZERO: inc = 1'b0;
            RM_UP:   inc = ~sign & (guard | sticky);
            default: inc = sign & (guard | sticky);
        endcase

        inexact = guard | sticky;
        rmag    = {1'b0, mag} + (INT_W+1)'(inc);
    end

endmodule

// File: rtl/fp2i_range.sv
module fp2i_range
    import fp2i_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             sign,
    input  logic             huge,
    input  logic [INT_W:0]   rmag,
    output logic             fits,
    output logic [INT_W-1:0] value,
    output logic [INT_W-1:0] max_pos
);

    localparam int             SHIFT   = INT_W - W;
    localparam logic [INT_W:0] ONE     = (INT_W+1)'(1);
    localparam logic [INT_W:0] LIM_NEG = ONE << (W - 1);
    localparam logic [INT_W:0] LIM_POS = LIM_NEG - ONE;

    logic [INT_W:0]   signed_val;
    logic [INT_W-1:0] left;

    always_comb begin
        fits       = !huge && (sign ? (rmag <= LIM_NEG) : (rmag <= LIM_POS));
        signed_val = sign ? (~rmag + ONE) : rmag;
        left       = signed_val[INT_W-1:0] << SHIFT;
        value      = $unsigned($signed(left) >>> SHIFT);
        max_pos    = LIM_POS[INT_W-1:0];
    end

endmodule

// File: rtl/fp2i_conv.sv
module fp2i_conv
    import fp2i_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [INT_W-1:0]  op_bits,
    input  logic              op_dbl,
    input  logic              dst_long,
    input  logic [1:0]        rnd_mode,
    input  logic              flag_clr,
    output logic              res_valid,
    output logic [INT_W-1:0]  res_int,
    output logic              res_invalid,
    output logic [FLAG_W-1:0] res_flags
);

    unpacked_t        up;
    logic [INT_W:0]   rmag;
    logic             inexact;
    logic             huge;
    logic             fits_w  [N_DST];
    logic [INT_W-1:0] val_w   [N_DST];
    logic [INT_W-1:0] max_w   [N_DST];

    state_t state_d;
    state_t state_q;
    flags_t new_flags;
    logic   ovf_c;
    logic   inv_c;

    fp2i_unpack u_unpack (
        .raw    (op_bits),
        .is_dbl (op_dbl),
        .up     (up)
    );

    fp2i_round u_round (
        .sign    (up.sign),
        .exp     (up.exp),
        .sig     (up.sig),
        .mode    (rmode_e'(rnd_mode)),
        .rmag    (rmag),
        .inexact (inexact),
        .huge    (huge)
    );

    for (genvar gi = 0; gi < N_DST; gi++) begin : g_dst
        fp2i_range #(
            .W (dst_width(gi))
        ) u_range (
            .sign    (up.sign),
            .huge    (huge),
            .rmag    (rmag),
            .fits    (fits_w[gi]),
            .value   (val_w[gi]),
            .max_pos (max_w[gi])
        );
    end

    always_comb begin
        ovf_c         = !up.special && !fits_w[dst_long];
        inv_c         = up.special || ovf_c;
        new_flags.inv = inv_c;
        new_flags.ovf = ovf_c;
        new_flags.inx = !inv_c && inexact;

        state_d       = state_q;
        state_d.valid = op_valid;
        if (op_valid) begin
            state_d.result = inv_c ? max_w[dst_long] : val_w[dst_long];
            state_d.inv    = inv_c;
        end
        state_d.flags = (flag_clr ? flags_t'('0) : state_q.flags)
                      | (op_valid ? new_flags : flags_t'('0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_valid   = state_q.valid;
    assign res_int     = state_q.result;
    assign res_invalid = state_q.inv;
    assign res_flags   = state_q.flags;

endmodule

// File: rtl/fp2i_conv_chk.sv
module fp2i_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic        dst_long,
    input logic        flag_clr,
    input logic        res_valid,
    input logic [63:0] res_int,
    input logic        res_invalid,
    input logic [2:0]  res_flags
);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(res_int) && $stable(res_invalid)));

    a_r10_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr |=> ((res_flags & $past(res_flags)) == $past(res_flags)));

    a_r10_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !op_valid) |=> (res_flags == 3'b000));

    a_r7_invalid_const: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_invalid) |->
            (res_int == ($past(dst_long) ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF)));

    a_r8_ovf_with_inv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_flags[1]) |-> res_flags[2]);

    a_r9_no_inexact_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_invalid && $past(flag_clr)) |-> !res_flags[0]);

    a_r6_sign_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(dst_long)) |-> (res_int[63:32] == {32{res_int[31]}}));

endmodule

bind fp2i_conv fp2i_conv_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .dst_long    (dst_long),
    .flag_clr    (flag_clr),
    .res_valid   (res_valid),
    .res_int     (res_int),
    .res_invalid (res_invalid),
    .res_flags   (res_flags)
);

// File: tb/fp2i_conv_tb.sv
module fp2i_conv_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [63:0] op_bits = '0;
    logic        op_dbl = 1'b0;
    logic        dst_long = 1'b0;
    logic [1:0]  rnd_mode = 2'd0;
    logic        flag_clr = 1'b0;
    logic        res_valid;
    logic [63:0] res_int;
    logic        res_invalid;
    logic [2:0]  res_flags;

    int    checks = 0;
    int    errors = 0;
    bit    chk_on = 1'b0;
    bit    timed_out = 1'b0;
    string cur_req = "R1";

    logic        exp_valid;
    logic [63:0] exp_int;
    logic        exp_inv;
    logic [2:0]  exp_flags;
    string       exp_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp2i_conv dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_bits     (op_bits),
        .op_dbl      (op_dbl),
        .dst_long    (dst_long),
        .rnd_mode    (rnd_mode),
        .flag_clr    (flag_clr),
        .res_valid   (res_valid),
        .res_int     (res_int),
        .res_invalid (res_invalid),
        .res_flags   (res_flags)
    );

    // Behavioural reference: real arithmetic from the operand bits.
    function automatic void ref_conv(input logic [63:0] b, input logic dbl, input logic lng,
                                     input logic [1:0] m, output logic [63:0] res,
                                     output logic inv, output logic [2:0] fl);
        real r;
        real f;
        real lim;
        logic special;
        logic [10:0] e11;
        if (dbl) begin
            special = (b[62:52] == 11'h7FF);
            r = $bitstoreal(b);
        end else begin
            special = (b[30:23] == 8'hFF);
            if (b[30:23] == 8'h00) begin
                r = b[22:0];
                for (int k = 0; k < 149; k++) r = r / 2.0;
                if (b[31]) r = -r;
            end else begin
                e11 = {3'b000, b[30:23]} + 11'd896;
                r = $bitstoreal({b[31], e11, b[22:0], 29'b0});
            end
        end
        lim = lng ? 9223372036854775808.0 : 2147483648.0;
        if (special) begin
            inv = 1'b1;
            fl  = 3'b100;
            res = lng ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
            return;
        end
        case (m)
            2'd0: begin
                f = $floor(r);
                if (r - f > 0.5) f = f + 1.0;
                else if ((r - f == 0.5) && ($floor(f / 2.0) * 2.0 != f)) f = f + 1.0;
            end
            2'd1: f = (r < 0.0) ? $ceil(r) : $floor(r);
            2'd2: f = $ceil(r);
            default: f = $floor(r);
        endcase
        if (f >= lim || f < -lim) begin
            inv = 1'b1;
            fl  = 3'b110;
            res = lng ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
        end else begin
            inv = 1'b0;
            res = longint'(f);
            fl  = {2'b00, (f != r)};
        end
    endfunction

    always @(posedge clk) begin
        logic [63:0] m_res;
        logic        m_inv;
        logic [2:0]  m_fl;
        if (!rst_n) begin
            exp_valid = 1'b0;
            exp_int   = '0;
            exp_inv   = 1'b0;
            exp_flags = '0;
            exp_req   = "R1";
        end else begin
            m_fl = '0;
            if (op_valid) begin
                ref_conv(op_bits, op_dbl, dst_long, rnd_mode, m_res, m_inv, m_fl);
                exp_int = m_res;
                exp_inv = m_inv;
            end
            exp_valid = op_valid;
            exp_flags = (flag_clr ? 3'b000 : exp_flags) | (op_valid ? m_fl : 3'b000);
            exp_req   = op_valid ? cur_req : (flag_clr ? "R10" : "R2");
        end
        chk_on = 1'b1;
    end

    always @(negedge clk) begin
        if (chk_on) begin
            checks++;
            if (res_valid !== exp_valid || res_int !== exp_int ||
                res_invalid !== exp_inv || res_flags !== exp_flags) begin
                errors++;
                $display("FAIL %s: actual valid=%0b int=%h inv=%0b flags=%b expected valid=%0b int=%h inv=%0b flags=%b",
                         exp_req, res_valid, res_int, res_invalid, res_flags,
                         exp_valid, exp_int, exp_inv, exp_flags);
            end
        end
    end

    task automatic do_op(input logic [63:0] b, input logic dbl, input logic lng,
                         input logic [1:0] m, input logic clr, input string req);
        @(negedge clk);
        op_valid = 1'b1;
        op_bits  = b;
        op_dbl   = dbl;
        dst_long = lng;
        rnd_mode = m;
        flag_clr = clr;
        cur_req  = req;
    endtask

    task automatic idle(input int n, input logic clr);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            op_bits  = 64'hFFFF_0000_FFFF_0000;
            flag_clr = clr;
            cur_req  = "R2";
        end
    endtask

    task automatic run_all();
        logic [63:0] seed;
        logic [63:0] rb;
        logic [10:0] ex;
        logic [7:0]  es;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;                                     // R1 checked during reset
        idle(2, 1'b0);
        // R3 nearest-even ties
        do_op($realtobits(2.5), 1, 1, 2'd0, 1'b1, "R3");
        do_op($realtobits(3.5), 1, 1, 2'd0, 1'b0, "R3");
        do_op($realtobits(-2.5), 1, 0, 2'd0, 1'b0, "R3");
        do_op($realtobits(2.6), 1, 0, 2'd0, 1'b0, "R3");
        // R4 directed modes
        for (int md = 1; md < 4; md++) begin
            do_op($realtobits(1.25), 1, 0, 2'(md), 1'b0, "R4");
            do_op($realtobits(-1.75), 1, 1, 2'(md), 1'b0, "R4");
        end
        // R2 hold and idle
        idle(3, 1'b0);
        // R10 clear while idle then clear with op
        idle(1, 1'b1);
        do_op($realtobits(7.0), 1, 1, 2'd0, 1'b0, "R10");
        do_op($realtobits(0.5), 1, 1, 2'd1, 1'b0, "R10");
        do_op($realtobits(4.0), 1, 1, 2'd0, 1'b1, "R10");
        // R5 single precision, upper bits ignored
        do_op(64'h0000_0000_4020_0000, 0, 0, 2'd0, 1'b0, "R5");
        do_op(64'hDEAD_BEEF_4020_0000, 0, 0, 2'd2, 1'b0, "R5");
        do_op(64'hFFFF_FFFF_BF40_0000, 0, 1, 2'd3, 1'b0, "R5");
        // R6 widths: 64-bit value, negative 32-bit sign extension
        do_op($realtobits(1.0e15), 1, 1, 2'd0, 1'b0, "R6");
        do_op($realtobits(-123456.0), 1, 0, 2'd1, 1'b0, "R6");
        do_op(64'h0000_0000_4F32_D05E, 0, 1, 2'd1, 1'b0, "R6");
        // R7 NaN and infinities
        do_op(64'h7FF8_0000_0000_0000, 1, 1, 2'd0, 1'b1, "R7");
        do_op(64'hFFF0_0000_0000_0000, 1, 0, 2'd0, 1'b1, "R7");
        do_op(64'h0000_0000_7F80_0000, 0, 0, 2'd2, 1'b1, "R7");
        do_op(64'h1234_5678_7FC0_0001, 0, 1, 2'd1, 1'b1, "R7");
        // R8 range limits
        do_op($realtobits(2147483647.5), 1, 0, 2'd0, 1'b1, "R8");
        do_op($realtobits(2147483647.5), 1, 0, 2'd1, 1'b1, "R8");
        do_op($realtobits(-2147483648.4), 1, 0, 2'd0, 1'b1, "R8");
        do_op($realtobits(-2147483648.4), 1, 0, 2'd3, 1'b1, "R8");
        do_op($realtobits(9223372036854775808.0), 1, 1, 2'd0, 1'b1, "R8");
        do_op($realtobits(-9223372036854775808.0), 1, 1, 2'd0, 1'b1, "R8");
        do_op($realtobits(1.0e30), 1, 1, 2'd3, 1'b1, "R8");
        do_op(64'h0000_0000_4F32_D05E, 0, 0, 2'd1, 1'b1, "R8");
        // R9 inexact only on valid results
        do_op($realtobits(5.0), 1, 1, 2'd2, 1'b1, "R9");
        do_op($realtobits(5.1), 1, 1, 2'd2, 1'b1, "R9");
        do_op($realtobits(3.0e9), 1, 0, 2'd0, 1'b1, "R9");
        // R11 subnormals
        do_op(64'h0000_0000_0000_0001, 1, 1, 2'd2, 1'b1, "R11");
        do_op(64'h0000_0000_0000_0001, 1, 1, 2'd0, 1'b0, "R11");
        do_op(64'h8000_0000_0000_0001, 1, 0, 2'd3, 1'b0, "R11");
        do_op(64'h0000_0000_0000_0001, 0, 0, 2'd2, 1'b0, "R11");
        do_op(64'h0000_0000_8000_0001, 0, 1, 2'd3, 1'b0, "R11");
        do_op(64'h0000_0000_8000_0001, 0, 1, 2'd1, 1'b0, "R11");
        do_op(64'h8000_0000_0000_0000, 1, 1, 2'd2, 1'b0, "R11");
        idle(2, 1'b0);
        // random double and single operands across modes and widths (R3 R4 R8)
        seed = 64'h0123_4567_89AB_CDEF;
        for (int i = 0; i < 300; i++) begin
            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
            if (seed[0]) begin
                ex = 11'd1018 + 11'(seed[40:34] % 7'd70);
                rb = {seed[63], ex, seed[52:1]};
                do_op(rb, 1, seed[33], seed[32:31], seed[30] & seed[29], "R4");
            end else begin
                es = 8'd124 + 8'(seed[40:35] % 6'd44);
                rb = {seed[62:31], seed[63], es, seed[24:2]};
                do_op(rb, 0, seed[30], seed[29:28], seed[27] & seed[26], "R3");
            end
        end
        idle(3, 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            errors++;
            $display("FAIL R2: watchdog expired, actual running expected finished");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule